// File: doc/BRIEF.md
# Audio Decoder Bring-Up Sequencer

This block powers up a serial audio decoder chip by driving a register-access master that sits on a two-wire control bus. A single start pulse begins a fixed sequence. First the block reads the device identity register and compares the byte returned with an expected value. It then streams a long configuration table of register/value pairs from an external memory. After the table it writes the board-level output-format registers. Last, it issues the run command and then the play command.

The block asks for one register access at a time. It holds each request until the master returns a response. Each response reports whether the device acknowledged and, for a read, the byte that came back. On any missing acknowledge or a wrong identity the sequence stops at once. The block then reports a failure code and the position at which it stopped.

Top module: `dec_init_seq`

## Requirements
- R1: A start pulse seen while the block is not busy raises busy_o on the next cycle, and the first request is a read (req_rd_o=1) of register 0x01.
- R2: If the identity read returns with rsp_nack_i=1, the sequence fails with fail_code_o=1 and no further request is issued.
- R3: If the identity byte differs from the DEV_ID parameter (default 0xAC), the sequence fails with fail_code_o=2 and no further request is issued.
- R4: After a good identity, exactly TBL_LEN writes (req_rd_o=0) are issued. Write k uses the register and value that the table returned for index k, for k ascending from 0. The table answers one cycle after tbl_idx_o is presented.
- R5: A not-acknowledged table write ends the sequence with fail_code_o=3, and fail_idx_o holds that write's table index.
- R6: The table is followed by the output-format writes in this order: register 0x84 with 0x01, register 0x85 with 0x21, register 0x24 with 0x04.
- R7: The last two writes are register 0x72 with 0x01 (run), then register 0x13 with 0x01 (play). After the play write is acknowledged, done_o rises.
- R8: A not-acknowledged write among the five final writes ends the sequence with fail_code_o=4, and fail_idx_o holds that write's position (0 to 4) within the final list.
- R9: busy_o stays high from the accepted start until done_o or fail_o rises. At most one of busy_o, done_o and fail_o is high. A start pulse during busy_o has no effect on the request stream.
- R10: A request (req_o=1) holds its fields steady until the cycle rsp_valid_i is high. A still-high req_o on the following cycle is a new request.
- R11: After reset, busy_o, done_o, fail_o and req_o are low. done_o and fail_o stay high until the next accepted start, and fail_code_o is 0 whenever done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| fail_o | output | 1 | Sequence aborted |
| fail_code_o | output | 3 | 1 no ID ack, 2 wrong ID, 3 table NACK, 4 final-write NACK |
| fail_idx_o | output | IW | Table index or final-list position of the failure |
| tbl_idx_o | output | IW | Configuration table index |
| tbl_reg_i | input | AW | Register field of the table entry (one cycle later) |
| tbl_val_i | input | DW | Value field of the table entry (one cycle later) |
| req_o | output | 1 | Register access request |
| req_rd_o | output | 1 | 1 read, 0 write |
| req_reg_o | output | AW | Device register address |
| req_wdata_o | output | DW | Write value |
| rsp_valid_i | input | 1 | Access finished |
| rsp_nack_i | input | 1 | Device did not acknowledge |
| rsp_rdata_i | input | DW | Byte read |

## Verification
The bench places a missing acknowledge on every table position and on every final-write position of a short table. A design that miscounts there would report the wrong index, carry on past the failure, or confuse code 3 with code 4. It also checks a missing identity acknowledge against a wrong identity byte, since a design that merged them would report one code for both. The response timing is varied, including back-to-back requests in the final list. This exposes a design that drops a request held across a response, or that latches a table entry before the table has answered. A start pulse in the middle of a run must leave the request log unchanged.

// File: rtl/dec_init_pkg.sv
package dec_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ID    = 3'd1,
    ST_FETCH = 3'd2,
    ST_LOAD  = 3'd3,
    ST_TWR   = 3'd4,
    ST_TAIL  = 3'd5,
    ST_DONE  = 3'd6,
    ST_FAIL  = 3'd7
  } seq_state_t;

  localparam int TAIL_N = 5;
  localparam int TAIL_W = 3;

  localparam logic [2:0] FC_NONE    = 3'd0;
  localparam logic [2:0] FC_NO_ID   = 3'd1;
  localparam logic [2:0] FC_BAD_ID  = 3'd2;
  localparam logic [2:0] FC_TBL     = 3'd3;
  localparam logic [2:0] FC_TAIL    = 3'd4;

  localparam logic [7:0] ID_REG = 8'h01;
endpackage

// File: rtl/dec_step_cnt.sv
module dec_step_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr_i | inc_i;
    q_d  = clr_i ? '0 : q_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/dec_tail_rom.sv
module dec_tail_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [dec_init_pkg::TAIL_W-1:0] sel_i,
  output logic [AW-1:0]                   reg_o,
  output logic [DW-1:0]                   val_o
);
  // Order is behaviour: output format, then run, then play.
  always_comb begin
    case (sel_i)
      3'd0:    begin reg_o = AW'(8'h84); val_o = DW'(8'h01); end
      3'd1:    begin reg_o = AW'(8'h85); val_o = DW'(8'h21); end
      3'd2:    begin reg_o = AW'(8'h24); val_o = DW'(8'h04); end
      3'd3:    begin reg_o = AW'(8'h72); val_o = DW'(8'h01); end
      default: begin reg_o = AW'(8'h13); val_o = DW'(8'h01); end
    endcase
  end
endmodule

// File: rtl/dec_init_seq.sv
module dec_init_seq #(
  parameter int         TBL_LEN = 2007,
  parameter logic [7:0] DEV_ID  = 8'hAC,
  parameter int         AW      = 8,
  parameter int         DW      = 8,
  localparam int        CW      = $clog2(TBL_LEN + 1),
  localparam int        IW      = (CW > 3) ? CW : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [2:0]    fail_code_o,
  output logic [IW-1:0] fail_idx_o,
  output logic [IW-1:0] tbl_idx_o,
  input  logic [AW-1:0] tbl_reg_i,
  input  logic [DW-1:0] tbl_val_i,
  output logic          req_o,
  output logic          req_rd_o,
  output logic [AW-1:0] req_reg_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_nack_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  import dec_init_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(TBL_LEN - 1);
  localparam logic [TAIL_W-1:0] LAST_TAIL = TAIL_W'(TAIL_N - 1);

  seq_state_t         st_q, st_d;
  logic [IW-1:0]      idx_q;
  logic [TAIL_W-1:0]  tsel_q;
  logic               idx_clr, idx_inc, tsel_clr, tsel_inc;
  logic [AW-1:0]      pair_reg_q;
  logic [DW-1:0]      pair_val_q;
  logic               pair_en;
  logic [2:0]         fcode_d, fcode_q;
  logic [IW-1:0]      fidx_d, fidx_q;
  logic               fail_en;
  logic [AW-1:0]      tail_reg;
  logic [DW-1:0]      tail_val;
  logic               accept;

  dec_step_cnt #(.W(IW)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr_i(idx_clr), .inc_i(idx_inc), .q_o(idx_q)
  );

  dec_step_cnt #(.W(TAIL_W)) u_tsel (
    .clk(clk), .rst_n(rst_n), .clr_i(tsel_clr), .inc_i(tsel_inc), .q_o(tsel_q)
  );

  dec_tail_rom #(.AW(AW), .DW(DW)) u_tail (
    .sel_i(tsel_q), .reg_o(tail_reg), .val_o(tail_val)
  );

  assign accept = start_i & ((st_q == ST_IDLE) | (st_q == ST_DONE) | (st_q == ST_FAIL));

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    idx_clr  = 1'b0;
    idx_inc  = 1'b0;
    tsel_clr = 1'b0;
    tsel_inc = 1'b0;
    pair_en  = 1'b0;
    fail_en  = 1'b0;
    fcode_d  = fcode_q;
    fidx_d   = fidx_q;
    case (st_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (accept) begin
          st_d     = ST_ID;
          idx_clr  = 1'b1;
          tsel_clr = 1'b1;
          fail_en  = 1'b1;
          fcode_d  = FC_NONE;
          fidx_d   = '0;
        end
      end
      ST_ID: begin
        if (rsp_valid_i) begin
          if (rsp_nack_i) begin
            st_d = ST_FAIL; fail_en = 1'b1; fcode_d = FC_NO_ID;
          end else if (rsp_rdata_i[7:0] != DEV_ID) begin
            st_d = ST_FAIL; fail_en = 1'b1; fcode_d = FC_BAD_ID;
          end else begin
            st_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: st_d = ST_LOAD;
      ST_LOAD: begin
        pair_en = 1'b1;
        st_d    = ST_TWR;
      end
      ST_TWR: begin
        if (rsp_valid_i) begin
          if (rsp_nack_i) begin
            st_d = ST_FAIL; fail_en = 1'b1; fcode_d = FC_TBL; fidx_d = idx_q;
          end else if (idx_q == LAST_IDX) begin
            st_d = ST_TAIL;
          end else begin
            idx_inc = 1'b1;
            st_d    = ST_FETCH;
          end
        end
      end
      ST_TAIL: begin
        if (rsp_valid_i) begin
          if (rsp_nack_i) begin
            st_d = ST_FAIL; fail_en = 1'b1; fcode_d = FC_TAIL; fidx_d = IW'(tsel_q);
          end else if (tsel_q == LAST_TAIL) begin
            st_d = ST_DONE;
          end else begin
            tsel_inc = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_reg_q <= '0;
      pair_val_q <= '0;
    end else if (pair_en) begin
      pair_reg_q <= tbl_reg_i;
      pair_val_q <= tbl_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcode_q <= FC_NONE;
      fidx_q  <= '0;
    end else if (fail_en) begin
      fcode_q <= fcode_d;
      fidx_q  <= fidx_d;
    end
  end

  // Outputs
  always_comb begin
    busy_o      = (st_q == ST_ID) | (st_q == ST_FETCH) | (st_q == ST_LOAD) |
                  (st_q == ST_TWR) | (st_q == ST_TAIL);
    done_o      = (st_q == ST_DONE);
    fail_o      = (st_q == ST_FAIL);
    fail_code_o = fcode_q;
    fail_idx_o  = fidx_q;
    tbl_idx_o   = idx_q;
    req_o       = (st_q == ST_ID) | (st_q == ST_TWR) | (st_q == ST_TAIL);
    req_rd_o    = (st_q == ST_ID);
    req_reg_o   = '0;
    req_wdata_o = '0;
    case (st_q)
      ST_ID:   req_reg_o = AW'(ID_REG);
      ST_TWR:  begin req_reg_o = pair_reg_q; req_wdata_o = pair_val_q; end
      ST_TAIL: begin req_reg_o = tail_reg;   req_wdata_o = tail_val;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/dec_init_seq_chk.sv
module dec_init_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [2:0]    fail_code_o,
  input logic          req_o,
  input logic          req_rd_o,
  input logic [AW-1:0] req_reg_o,
  input logic [DW-1:0] req_wdata_o,
  input logic          rsp_valid_i
);
  assert_first_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (req_o && req_rd_o && req_reg_o == AW'(8'h01)));

  assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, done_o, fail_o}));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !rsp_valid_i) |=> (req_o && $stable(req_rd_o) &&
                                 $stable(req_reg_o) && $stable(req_wdata_o)));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  assert_fail_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);

  assert_done_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (fail_code_o == 3'd0));

  assert_fail_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (fail_code_o >= 3'd1 && fail_code_o <= 3'd4));
endmodule

bind dec_init_seq dec_init_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .fail_o(fail_o), .fail_code_o(fail_code_o),
  .req_o(req_o), .req_rd_o(req_rd_o), .req_reg_o(req_reg_o),
  .req_wdata_o(req_wdata_o), .rsp_valid_i(rsp_valid_i)
);

// File: tb/dec_init_seq_tb.sv
module dec_init_seq_tb_top;
  localparam int N  = 5;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fail;
  logic [2:0] fcode;
  logic [IW-1:0] fidx, tidx;
  logic [7:0] tbl_reg, tbl_val;
  logic req, req_rd;
  logic [7:0] req_reg, req_wd;
  logic rsp_valid, rsp_nack;
  logic [7:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int nack_at = -1;
  logic [7:0] id_val = 8'hAC;

  logic       m_busy, m_nack;
  int         m_cnt, txn_n;
  logic       log_rd  [0:31];
  logic [7:0] log_reg [0:31];
  logic [7:0] log_wd  [0:31];

  always #10 clk = ~clk;

  dec_init_seq #(.TBL_LEN(N), .DEV_ID(8'hAC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_code_o(fcode), .fail_idx_o(fidx), .tbl_idx_o(tidx),
    .tbl_reg_i(tbl_reg), .tbl_val_i(tbl_val), .req_o(req), .req_rd_o(req_rd),
    .req_reg_o(req_reg), .req_wdata_o(req_wd), .rsp_valid_i(rsp_valid),
    .rsp_nack_i(rsp_nack), .rsp_rdata_i(rsp_rdata)
  );

  function automatic logic [7:0] exp_reg(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] exp_val(input int i);
    return 8'(((i * 13) ^ 8'h5A) & 255);
  endfunction
  function automatic logic [7:0] tail_reg(input int k);
    case (k) 0: return 8'h84; 1: return 8'h85; 2: return 8'h24; 3: return 8'h72; default: return 8'h13; endcase
  endfunction
  function automatic logic [7:0] tail_val(input int k);
    case (k) 1: return 8'h21; 2: return 8'h04; default: return 8'h01; endcase
  endfunction

  // Table memory with one cycle of latency
  always @(posedge clk) begin
    tbl_reg <= exp_reg(int'(tidx));
    tbl_val <= exp_val(int'(tidx));
  end

  // Register-access master model with varying response delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_nack <= 1'b0; m_cnt <= 0; txn_n <= 0;
      rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_rdata <= 8'h00;
    end else begin
      rsp_valid <= 1'b0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          rsp_valid <= 1'b1; rsp_nack <= m_nack; rsp_rdata <= id_val; m_busy <= 1'b0;
        end else m_cnt <= m_cnt - 1;
      end else if (req && !rsp_valid) begin
        m_busy <= 1'b1;
        m_cnt  <= txn_n % 3;
        m_nack <= (txn_n == nack_at);
        if (txn_n < 32) begin
          log_rd[txn_n] <= req_rd; log_reg[txn_n] <= req_reg; log_wd[txn_n] <= req_wd;
        end
        txn_n <= txn_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 500; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input logic [7:0] idv, input int nk);
    id_val = idv; nack_at = nk;
    do_reset();
    pulse_start();
    wait_end();
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset();
    chk(!busy && !done && !fail && !req, "R11 reset idle", {busy, done, fail, req}, 0);

    // R1, R4, R6, R7 full run
    id_val = 8'hAC; nack_at = -1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy, "R1 busy after start", busy, 1);
    chk(req && req_rd && req_reg == 8'h01, "R1 id read", req_reg, 1);
    wait_end();
    chk(done && !fail && !busy, "R7 done", done, 1);
    chk(txn_n == N + 6, "R4 request count", txn_n, N + 6);
    chk(log_rd[0] == 1'b1 && log_reg[0] == 8'h01, "R1 first request", log_reg[0], 1);
    for (int k = 0; k < N; k++) begin
      chk(!log_rd[k+1] && log_reg[k+1] == exp_reg(k) && log_wd[k+1] == exp_val(k),
          "R4 table pair", log_reg[k+1], exp_reg(k));
    end
    for (int k = 0; k < 5; k++) begin
      chk(!log_rd[N+1+k] && log_reg[N+1+k] == tail_reg(k) && log_wd[N+1+k] == tail_val(k),
          (k < 3) ? "R6 format write" : "R7 run/play write", log_reg[N+1+k], tail_reg(k));
    end
    repeat (5) @(negedge clk);
    chk(done && !req && fcode == 3'd0, "R11 done held", done, 1);

    // R2 identity not acknowledged
    run_case(8'hAC, 0);
    chk(fail && fcode == 3'd1, "R2 fail code", fcode, 1);
    repeat (4) @(negedge clk);
    chk(txn_n == 1 && !req && fail, "R2 no further request", txn_n, 1);

    // R3 wrong identity
    run_case(8'hAB, -1);
    chk(fail && fcode == 3'd2, "R3 fail code", fcode, 2);
    repeat (4) @(negedge clk);
    chk(txn_n == 1 && !req, "R3 no further request", txn_n, 1);

    // R5 NACK at every table position
    for (int k = 0; k < N; k++) begin
      run_case(8'hAC, 1 + k);
      repeat (3) @(negedge clk);
      chk(fail && fcode == 3'd3, "R5 fail code", fcode, 3);
      chk(int'(fidx) == k, "R5 fail index", fidx, k);
      chk(txn_n == 2 + k, "R5 stop after nack", txn_n, 2 + k);
    end

    // R8 NACK at every final-write position
    for (int k = 0; k < 5; k++) begin
      run_case(8'hAC, N + 1 + k);
      repeat (3) @(negedge clk);
      chk(fail && fcode == 3'd4, "R8 fail code", fcode, 4);
      chk(int'(fidx) == k, "R8 fail position", fidx, k);
      chk(txn_n == N + 2 + k, "R8 stop after nack", txn_n, N + 2 + k);
    end

    // R9 start during busy has no effect
    id_val = 8'hAC; nack_at = -1;
    do_reset();
    pulse_start();
    repeat (8) @(negedge clk);
    chk(busy, "R9 busy mid run", busy, 1);
    pulse_start();
    chk(busy, "R9 busy after ignored start", busy, 1);
    wait_end();
    chk(done && txn_n == N + 6, "R9 stream unchanged", txn_n, N + 6);
    for (int k = 0; k < N; k++) begin
      chk(log_reg[k+1] == exp_reg(k), "R9 table order kept", log_reg[k+1], exp_reg(k));
    end

    // R11 restart from done
    pulse_start();
    chk(busy && !done, "R11 restart clears done", done, 0);
    wait_end();
    chk(done, "R11 restart completes", done, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule